// File: doc/BRIEF.md
# Flash Program/Erase Algorithm Engine

This block stands behind a flash command decoder and carries out the three write operations the decoder can request: a single-byte program, an erase of one sector and an erase of the whole array. It owns a synchronous byte array whose depth is set by a parameter. Each operation keeps the engine busy for a parameterised number of clock cycles. The array is then updated in one step, and the engine goes back to array-read mode without any further request.

While an operation runs, host reads do not return array contents. They return a status byte instead. Bit 7 is a polling bit: it carries the inverted bit 7 of the byte being programmed, or 0 during an erase. Bit 6 is a toggle bit that changes on every new read strobe. A host can therefore poll either bit to find out when the operation has finished. A one-cycle done pulse marks the end of each operation.

Top module: `flash_algo_engine`

## Requirements
- R1: During and after reset, busy_o, done_o and rd_data_o are 0, and every array byte reads FFh.
- R2: An accepted request raises busy_o at the next clock edge. busy_o then stays high for exactly PROG_CYC cycles for a program, SECT_CYC cycles for a sector erase and CHIP_CYC cycles for a chip erase.
- R3: A program stores (old byte AND req_data_i) at req_addr_i. Bits can only go from 1 to 0, so programming FFh over a byte leaves it unchanged.
- R4: A sector erase sets to FFh every byte whose top SECT_BITS address bits equal those of req_addr_i. Bytes in other sectors are left untouched.
- R5: A chip erase sets every byte of the array to FFh.
- R6: A read while busy returns a status byte. Bit 7 is the inverse of bit 7 of the program data during a program, and 0 during either erase. Bits 5..0 are 0.
- R7: The status bit 6 is cleared when an operation starts. It flips on each rising edge of rd_i while busy, so the first status read shows 1. Holding rd_i high does not flip it again, and after the operation ends reads return array data.
- R8: done_o is high for exactly one cycle: the first cycle in which busy_o is low after an operation.
- R9: Requests that arrive while busy_o is high are ignored, and they leave the array unaffected.
- R10: If several requests are raised in the same cycle, the priority order is chip erase, then sector erase, then program. Only the winning request is executed.
- R11: rd_data_o is registered. It updates at a clock edge where rd_i is high, showing array data at rd_addr_i when the engine is idle, and it holds its value while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_prog_i | input | 1 | Program-byte request |
| req_sect_i | input | 1 | Sector-erase request |
| req_chip_i | input | 1 | Chip-erase request |
| req_addr_i | input | ADDR_W | Target byte address; its top bits select the sector |
| req_data_i | input | 8 | Program data |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Registered read data or status byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The core sequence is a table of programs and erases. It includes:
- a repeated program of one byte, which shows whether programming ANDs into the cell or overwrites it;
- a sector erase that sits between bytes programmed in other sectors, which shows whether the sector select uses the correct address bits;
- a closing chip erase.

After every entry the whole array is compared with a model, and the busy length is measured, which separates the three timer values.

Directed cases cover the following:
- Status reads during a program with bit 7 of the data low, and during an erase, tell the two polling rules apart.
- A held strobe tells an edge-triggered toggle from a level-triggered one.
- A chip erase requested while a program is running must be dropped.
- Two requests raised together must resolve to the erase.

// File: rtl/flash_algo_pkg.sv
package flash_algo_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } algo_op_e;
endpackage

// File: rtl/algo_timer.sv
module algo_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign busy_o = run_q;
  assign last_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= load_val_i;
    end else if (last_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r2_busy_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o |=> busy_o);
  a_r2_ends_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !load_i |=> !busy_o);
  a_r9_no_reload_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_i);
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_algo_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  algo_op_e          op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*8-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic [7:0] cell_q;
    logic       hit_erase;
    logic       hit_prog;

    assign hit_erase = commit_i && ((op_i == OP_CHIP) ||
                       ((op_i == OP_SECT) &&
                        (IDX[ADDR_W-1 -: SECT_BITS] == addr_i[ADDR_W-1 -: SECT_BITS])));
    assign hit_prog  = commit_i && (op_i == OP_PROG) && (addr_i == IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cell_q <= 8'hFF;
      else if (hit_erase) cell_q <= 8'hFF;
      else if (hit_prog)  cell_q <= cell_q & data_i;
    end

    assign flat[i*8 +: 8] = cell_q;
  end

  assign rd_data_o = flat[{rd_addr_i, 3'b000} +: 8];
endmodule

// File: rtl/algo_status.sv
module algo_status
  import flash_algo_pkg::*;
(
  input  algo_op_e   op_i,
  input  logic       data_msb_i,
  input  logic       tgl_i,
  output logic [7:0] status_o
);
  logic poll_bit;

  assign poll_bit = (op_i == OP_PROG) ? ~data_msb_i : 1'b0;
  assign status_o = {poll_bit, tgl_i, 6'b00_0000};
endmodule

// File: rtl/flash_algo_engine.sv
module flash_algo_engine
  import flash_algo_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_BITS = 2,
  parameter int PROG_CYC  = 4,
  parameter int SECT_CYC  = 12,
  parameter int CHIP_CYC  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_prog_i,
  input  logic              req_sect_i,
  input  logic              req_chip_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAX_CYC = (CHIP_CYC > SECT_CYC) ?
                           ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                           ((SECT_CYC > PROG_CYC) ? SECT_CYC : PROG_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  algo_op_e          op_q, sel_op;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [7:0]        lat_data_q;
  logic              tgl_q, tgl_d, rd_q, done_q;
  logic [7:0]        rd_data_q, arr_data, status;
  logic              accept, last, busy;
  logic [CNT_W-1:0]  load_val;

  // chip > sector > program
  always_comb begin
    if (req_chip_i)      sel_op = OP_CHIP;
    else if (req_sect_i) sel_op = OP_SECT;
    else if (req_prog_i) sel_op = OP_PROG;
    else                 sel_op = OP_NONE;
  end

  assign accept = !busy && (sel_op != OP_NONE);

  always_comb begin
    case (sel_op)
      OP_CHIP: load_val = CNT_W'(CHIP_CYC - 1);
      OP_SECT: load_val = CNT_W'(SECT_CYC - 1);
      default: load_val = CNT_W'(PROG_CYC - 1);
    endcase
  end

  algo_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (load_val),
    .busy_o     (busy),
    .last_o     (last)
  );

  flash_byte_array #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (last),
    .op_i      (op_q),
    .addr_i    (lat_addr_q),
    .data_i    (lat_data_q),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (arr_data)
  );

  algo_status u_status (
    .op_i       (op_q),
    .data_msb_i (lat_data_q[7]),
    .tgl_i      (tgl_d),
    .status_o   (status)
  );

  always_comb begin
    tgl_d = tgl_q;
    if (accept)                tgl_d = 1'b0;
    else if (busy && rd_i && !rd_q) tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_NONE;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      tgl_q      <= 1'b0;
      rd_q       <= 1'b0;
      done_q     <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (accept) begin
        op_q       <= sel_op;
        lat_addr_q <= req_addr_i;
        lat_data_q <= req_data_i;
      end
      tgl_q  <= tgl_d;
      rd_q   <= rd_i;
      done_q <= last;
      if (rd_i) rd_data_q <= busy ? status : arr_data;
    end
  end

  assign rd_data_o = rd_data_q;
  assign busy_o    = busy;
  assign done_o    = done_q;

  a_r8_done_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_prog_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rd_i && (op_q == OP_PROG) |=> rd_data_o[7] == ~lat_data_q[7]);
  a_r6_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rd_i && (op_q != OP_PROG) |=> !rd_data_o[7]);
  a_r6_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rd_i |=> rd_data_o[5:0] == 6'd0);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
  a_r9_latch_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q) && $stable(lat_addr_q) && $stable(lat_data_q));
endmodule

// File: tb/flash_algo_engine_bench.sv
`timescale 1ns/1ps
module flash_algo_engine_bench;
  localparam int PC = 10, SC = 20, CC = 30;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_prog = 1'b0, req_sect = 1'b0, req_chip = 1'b0;
  logic [7:0] req_addr = '0, req_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data_o;
  logic       busy_o, done_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [256];

  always #4 clk = ~clk;

  flash_algo_engine #(.ADDR_W(8), .SECT_BITS(2), .PROG_CYC(PC), .SECT_CYC(SC),
                      .CHIP_CYC(CC)) u_flash_algo_engine (
    .clk_i(clk), .rst_ni(rst_ni), .req_prog_i(req_prog), .req_sect_i(req_sect),
    .req_chip_i(req_chip), .req_addr_i(req_addr), .req_data_i(req_data),
    .rd_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .done_o(done_o));

  // {op[17:16], addr[15:8], data[7:0]}; op 1=program 2=sector 3=chip
  localparam logic [17:0] VEC [6] = '{
    {2'd1, 8'h10, 8'hA5}, {2'd1, 8'h10, 8'h0F}, {2'd1, 8'hC3, 8'h3C},
    {2'd1, 8'h47, 8'h81}, {2'd2, 8'h12, 8'h00}, {2'd3, 8'h00, 8'h00}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
    req_addr = a; req_data = d;
    req_prog = (op == 2'd1); req_sect = (op == 2'd2); req_chip = (op == 2'd3);
    @(negedge clk);
    req_prog = 0; req_sect = 0; req_chip = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rd_data_o;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy_o; i++) @(negedge clk);
  endtask

  task automatic model_apply(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
    for (int i = 0; i < 256; i++) begin
      if (op == 2'd3) mdl[i] = 8'hFF;
      else if (op == 2'd2 && i[7:6] == a[7:6]) mdl[i] = 8'hFF;
    end
    if (op == 2'd1) mdl[a] = mdl[a] & d;
  endtask

  task automatic scan(input string req);
    int bad = 0;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      rd(8'(i), v);
      if (v !== mdl[i]) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, held;
    int n;
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;

    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 done in reset", done_o, 0);
    chk("R1 rd_data in reset", rd_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(8'h33, v);
    chk("R1 erased after reset", v, 8'hFF);

    // table walk: R2 busy length, R8 done pulse, R3/R4/R5 array contents
    for (int k = 0; k < 6; k++) begin
      logic [1:0] op;
      int exp_n;
      op = VEC[k][17:16];
      exp_n = (op == 2'd1) ? PC : (op == 2'd2) ? SC : CC;
      issue(op, VEC[k][15:8], VEC[k][7:0]);
      count_busy(n);
      chk("R2 busy length", n, exp_n);
      chk("R8 done high after busy", done_o, 1);
      @(negedge clk);
      chk("R8 done single cycle", done_o, 0);
      model_apply(op, VEC[k][15:8], VEC[k][7:0]);
      scan((op == 2'd1) ? "R3 program AND" : (op == 2'd2) ? "R4 sector erase" : "R5 chip erase");
    end

    // R6/R7 program status, toggle and hold
    issue(2'd1, 8'h20, 8'h5A);
    rd(8'h77, v);
    chk("R6 R7 first status in program", v, 8'hC0);
    rd(8'h20, v);
    chk("R7 second status toggles", v, 8'h80);
    rd_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 held strobe no extra toggle", rd_data_o, 8'hC0);
    end
    rd_en = 1'b0;
    @(negedge clk);
    held = rd_data_o;
    @(negedge clk);
    chk("R11 hold while rd low", rd_data_o, held);
    wait_idle();
    rd(8'h20, v);
    chk("R7 array data after program", v, 8'h5A);
    rd(8'h20, v);
    chk("R7 toggle stopped", v, 8'h5A);

    // R6 erase status
    issue(2'd2, 8'h90, 8'h00);
    rd(8'h90, v);
    chk("R6 erase status first", v, 8'h40);
    rd(8'h05, v);
    chk("R6 erase status second", v, 8'h00);
    wait_idle();
    rd(8'h20, v);
    chk("R4 other sector kept", v, 8'h5A);

    // R9 request ignored while busy
    issue(2'd1, 8'h60, 8'h11);
    issue(2'd3, 8'h00, 8'h00);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R9 no operation started", busy_o, 0);
    rd(8'h20, v);
    chk("R9 chip erase ignored", v, 8'h5A);
    rd(8'h60, v);
    chk("R3 program stored", v, 8'h11);
    issue(2'd1, 8'h60, 8'hFF);
    wait_idle();
    rd(8'h60, v);
    chk("R3 no bit set by program", v, 8'h11);

    // R10 priority: sector over program
    req_addr = 8'h25; req_data = 8'h00; req_prog = 1'b1; req_sect = 1'b1;
    @(negedge clk);
    req_prog = 1'b0; req_sect = 1'b0;
    count_busy(n);
    chk("R10 sector erase wins length", n, SC);
    rd(8'h20, v);
    chk("R10 sector erased", v, 8'hFF);
    rd(8'h25, v);
    chk("R10 program dropped", v, 8'hFF);
    rd(8'h60, v);
    chk("R10 other sector kept", v, 8'h11);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule